// File: doc/BRIEF.md
# Serial Link Power and Lock Sequencer

This block steps a serial transmitter's output stage through three phases: off, locking and running. A power-down input and an input-supply-present flag decide whether the link may come up at all. A lock counter on the parallel clock stands in for the analog clock multiplier. It declares lock after a fixed number of parallel clocks and then lets the driver run. The block drives only control outputs: clock-multiplier enable, termination enable, output tri-state, forced zero-differential, and a link-ready flag that gates the upstream word framer.

A two-bit range select tells the clock multiplier which of four parallel-clock bands is in use. A change of band while running is treated as a fresh lock: the count starts again from zero. All pins are plain levels and there is no data stream through the block.

Top module: `lnk_pwr_seq`

## Requirements
- R1: While the effective power-down is low, the outputs are: pll_en=0, term_en=0, out_hiz=1, force_zero=0, link_ready=0.
- R2: The effective power-down is low whenever supply_ok is low, whatever pwr_up is.
- R3: In the cycle after effective power-down goes high, the block enters the locking state: pll_en=1, term_en=1, out_hiz=1, force_zero=1, link_ready=0.
- R4: link_ready rises exactly LOCK_CYCLES clock edges after the edge on which the block entered the locking state, and not before.
- R5: In the running state the outputs are: pll_en=1, term_en=1, out_hiz=0, force_zero=0, link_ready=1.
- R6: Power-down taken low in any state returns the block to the off state on the next edge, and the lock count starts from zero afterwards.
- R7: A change of rng_sel while running returns the block to the locking state on the next edge, with a full LOCK_CYCLES wait.
- R8: pll_band repeats rng_sel as sampled while the block is not off. The encoding is 0 for 3-5 MHz, 1 for 5-10, 2 for 10-20 and 3 for 20-35. The value is held while off.
- R9: framer_en equals link_ready at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_up | input | 1 | Power-down pin, high means powered |
| supply_ok | input | 1 | Input supply present |
| rng_sel | input | 2 | Clock range select |
| pll_en | output | 1 | Clock multiplier enable |
| term_en | output | 1 | Termination switched in |
| out_hiz | output | 1 | Driver tri-stated |
| force_zero | output | 1 | Termination holds differential at zero |
| link_ready | output | 1 | Lock complete, driver active |
| framer_en | output | 1 | Enable for the word framer |
| pll_band | output | 2 | Band code passed to the clock multiplier |

## Verification
The bench builds the block with LOCK_CYCLES set to 20, so a full lock wait fits in a few dozen cycles. This lets the test cover many power cycles, aborted locks and band changes. The exact rising edge of link_ready is compared against a bench cycle counter. It is checked both with one cycle to spare and on the exact cycle. The default of 16385 is only elaborated, because the counter width follows from the parameter.

// File: rtl/lnk_pwr_seq_pkg.sv
package lnk_pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOCK = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lnk_lock_cnt.sv
module lnk_lock_cnt #(
  parameter int LOCK_CYCLES = 16385,
  localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/lnk_pwr_seq.sv
module lnk_pwr_seq
  import lnk_pwr_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 16385,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic          supply_ok,
  input  logic [RW-1:0] rng_sel,
  output logic          pll_en,
  output logic          term_en,
  output logic          out_hiz,
  output logic          force_zero,
  output logic          link_ready,
  output logic          framer_en,
  output logic [RW-1:0] pll_band
);
  seq_state_t st, st_nx;
  logic eff_up, lock_done, clr_cnt, band_chg;

  assign eff_up   = pwr_up & supply_ok;
  assign band_chg = (st != ST_OFF) && (rng_sel != pll_band);

  always_comb begin
    st_nx = st;
    case (st)
      ST_OFF:  if (eff_up) st_nx = ST_LOCK;
      ST_LOCK: if (!eff_up) st_nx = ST_OFF;
               else if (lock_done) st_nx = ST_RUN;
      ST_RUN:  if (!eff_up) st_nx = ST_OFF;
               else if (band_chg) st_nx = ST_LOCK;
      default: st_nx = ST_OFF;
    endcase
  end

  assign clr_cnt = (st != ST_LOCK) || !eff_up || band_chg;

  lnk_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt),
    .run(st == ST_LOCK), .done(lock_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      pll_band <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != ST_OFF) pll_band <= rng_sel;
    end
  end

  assign pll_en     = (st != ST_OFF);
  assign term_en    = (st != ST_OFF);
  assign out_hiz    = (st != ST_RUN);
  assign force_zero = (st == ST_LOCK);
  assign link_ready = (st == ST_RUN);
  assign framer_en  = link_ready;

  assert_off_on_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_up && supply_ok) |=> !pll_en && out_hiz && !term_en);
  assert_supply_forces_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !link_ready);
  assert_ready_from_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(force_zero));
  assert_drive_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_zero && !out_hiz));
  assert_framer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    framer_en == link_ready);
  assert_band_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && pwr_up && supply_ok && rng_sel != pll_band) |=> force_zero);
endmodule

// File: tb/lnk_pwr_seq_tb_top.sv
module lnk_pwr_seq_tb_top;
  localparam int LC = 20;
  logic clk = 0, rst_n = 0, pwr_up = 0, supply_ok = 1;
  logic [1:0] rng_sel = 0;
  logic pll_en, term_en, out_hiz, force_zero, link_ready, framer_en;
  logic [1:0] pll_band;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lnk_pwr_seq #(.LOCK_CYCLES(LC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .supply_ok(supply_ok),
    .rng_sel(rng_sel), .pll_en(pll_en), .term_en(term_en), .out_hiz(out_hiz),
    .force_zero(force_zero), .link_ready(link_ready), .framer_en(framer_en),
    .pll_band(pll_band));

  function automatic logic [4:0] exp_vec(input int s);
    case (s)
      0: return 5'b00100;
      1: return 5'b11110;
      default: return 5'b11001;
    endcase
  endfunction

  task automatic chk(input string r, input int s);
    logic [4:0] a = {pll_en, term_en, out_hiz, force_zero, link_ready};
    checks++;
    if (a !== exp_vec(s) || framer_en !== link_ready) begin
      errors++;
      $display("FAIL %s got %b exp %b fr=%b", r, a, exp_vec(s), framer_en);
    end
  endtask

  task automatic chk_band(input string r, input logic [1:0] e);
    checks++;
    if (pll_band !== e) begin
      errors++;
      $display("FAIL %s band got %0d exp %0d", r, pll_band, e);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // bring up and check exact lock edge
  task automatic bring_up(input logic [1:0] b, input string r);
    rng_sel = b; pwr_up = 1; supply_ok = 1;
    step(1); chk({r, " R3"}, 1);
    chk_band({r, " R8"}, b);
    step(LC - 1); chk({r, " R4 early"}, 1);
    step(1); chk({r, " R4 exact R5"}, 2);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    step(2); chk("R1 reset", 0);
    rst_n = 1; step(2); chk("R1 idle", 0);
    // R2: supply absent blocks power-up
    supply_ok = 0; pwr_up = 1; step(3); chk("R2 no supply", 0);
    chk_band("R8 held off", 2'd0);
    pwr_up = 0; supply_ok = 1; step(1);
    bring_up(2'd2, "dir");
    // R2 supply loss while running
    supply_ok = 0; step(1); chk("R2 drop R6", 0);
    chk_band("R8 hold", 2'd2);
    supply_ok = 1; step(1); chk("R3 relock", 1);
    // R6 abort mid-lock then full count restarts
    step(LC / 2); pwr_up = 0; step(1); chk("R6 abort", 0);
    bring_up(2'd1, "R6 restart");
    // R7 band change while running
    rng_sel = 2'd3; step(1); chk("R7 relock", 1);
    chk_band("R7 band", 2'd3);
    step(LC - 1); chk("R7 early", 1);
    step(1); chk("R7 exact", 2);
    step(3); chk("R5 steady", 2);
    // random power cycles
    for (int i = 0; i < 30; i++) begin
      logic [1:0] b = 2'($urandom);
      int w = $urandom_range(1, LC + 5);
      pwr_up = 0; step(1); chk("R6 rand", 0);
      rng_sel = b; pwr_up = 1; step(1); chk("R3 rand", 1);
      if (w < LC) begin
        step(w); chk("R4 rand partial", 1);
      end else begin
        step(LC - 1); chk("R4 rand early", 1);
        step(1); chk("R4 rand exact", 2);
        chk_band("R8 rand", b);
        step(w - LC); chk("R5 rand hold", 2);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule